// File: doc/BRIEF.md
# Lockable System Control Register Bank

This block is a word-addressed bank of status and control registers for a small system on chip. It sits behind a plain 32-bit register bus with an address, a write strobe, a read strobe, write data and read data. It holds two identity words fixed at elaboration, a bank of oscillator setting words, and a key-protected lock. The lock guards a reset control word. Writing that word while the bank is unlocked sends a one-cycle system reset request. The bank also has a volatile flag word and a non-volatile flag word. Each flag word has its own set address and its own clear address, so software can change single bits without a read-modify-write.

A free-running tick counter advances at a nominal 24 MHz. A phase accumulator derives this rate from the bus clock, so the ratio between the two rates is exact over time. Six further offsets act as plain storage words. Any other offset reads zero and ignores writes, and the bank flags the access on an error strobe.

There are two resets. The bus reset `rst_n` clears the volatile state and leaves the bank locked. The power-on reset `por_n` clears only the non-volatile flags and the tick counter. A system reset that is wired back to `rst_n` therefore leaves both of those intact.

Top module: `sys_ctrl_bank`

## Requirements
- R1: Offset 0x000 reads the SYS_ID parameter and offset 0x084 reads the PROC_ID parameter; writes to them change nothing and raise no error.
- R2: The NUM_OSC oscillator words at offsets 0x00C + 4*i read back the last 32-bit value written and read OSC_RST after bus reset.
- R3: Writing exactly 0x0000A05F to the lock word at 0x020 unlocks the bank, and the lock word then reads 0x0000A05F (bit 16 clear).
- R4: Any other write to 0x020 stores the write data masked to bits 14:0 and leaves the bank locked; while locked the lock word reads bit 16 set with the stored value in bits 15:0.
- R5: Writing 0x030 ORs the write data into the volatile flags, writing 0x034 clears the flag bits set in the write data, reading 0x030 returns the flags and reading 0x034 returns zero.
- R6: The non-volatile flags behave the same way at 0x038 (set, read) and 0x03C (clear, reads zero); bus reset leaves them unchanged and only power-on reset clears them.
- R7: A write to 0x040 while unlocked stores write data bits 7:0, which offset 0x040 then reads back, and drives `rst_req` high for exactly the one cycle after the accepting clock edge; while locked the write changes nothing and gives no pulse.
- R8: Offset 0x05C reads a 32-bit counter that advances by TICK_HZ/CLK_HZ per clock through a phase accumulator (every second clock by default), ignores writes, and keeps counting through bus reset; power-on reset clears it.
- R9: An access, read or write, to an offset outside the map or not aligned to a word reads zero and writes nothing, and `bus_err` is high for the one cycle after that access.
- R10: Bus reset clears the volatile flags, the oscillator and storage words and the reset control word, and leaves the bank locked with the lock word reading 0x00010000.
- R11: Storage words at offsets 0x028, 0x02C, 0x044, 0x04C, 0x050 and 0x054 read back the last value written.
- R12: `bus_rdata` is zero in every cycle in which `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Bus reset, asynchronous, active low |
| por_n | input | 1 | Power-on reset for non-volatile flags and tick counter, active low |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current address |
| bus_err | output | 1 | One-cycle pulse after an access to an undefined offset |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench targets the lock boundary. It writes 0x0001A05F, which matches the key only in its low half, and checks that this write relocks the bank instead of unlocking it; a design that compared only 16 bits would unlock here and later give a reset pulse where none is due. A reset control write while locked has to leave both the stored value and `rst_req` unchanged. Two back-to-back writes while unlocked have to give two pulse cycles that line up exactly with the accepting edges, so a design that added a cycle of latency or dropped the second pulse shows up. The bench also probes unaligned and unmapped offsets next to real words, then asserts bus reset between writes to both flag words. Code that mixed up the two resets would lose the non-volatile flags or restart the tick counter, and the cycle-by-cycle model catches the counter drifting by even one tick.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   localparam int unsigned OFF_SYS_ID  = 32'h000;
   localparam int unsigned OFF_OSC0    = 32'h00C;
   localparam int unsigned OFF_LOCK    = 32'h020;
   localparam int unsigned OFF_FL_SET  = 32'h030;
   localparam int unsigned OFF_FL_CLR  = 32'h034;
   localparam int unsigned OFF_NV_SET  = 32'h038;
   localparam int unsigned OFF_NV_CLR  = 32'h03C;
   localparam int unsigned OFF_RST_CTL = 32'h040;
   localparam int unsigned OFF_TICK    = 32'h05C;
   localparam int unsigned OFF_PROC_ID = 32'h084;

   localparam int unsigned MAX_OSC = 5;
   localparam int unsigned NUM_SCR = 6;

   localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

   // byte offsets of the plain storage words
   function automatic int unsigned scr_offset(input int unsigned idx);
      case (idx)
         0: return 32'h028;
         1: return 32'h02C;
         2: return 32'h044;
         3: return 32'h04C;
         4: return 32'h050;
         default: return 32'h054;
      endcase
   endfunction

   typedef struct packed {
      logic sys_id;
      logic proc_id;
      logic lock;
      logic fl_set;
      logic fl_clr;
      logic nv_set;
      logic nv_clr;
      logic rst_ctl;
      logic tick;
      logic valid;
   } sel_t;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
   import sysctl_pkg::*;
#(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned NUM_OSC = 5
) (
   input  logic [ADDR_W-1:0]          addr,
   output sel_t                       sel,
   output logic [NUM_OSC-1:0]         osc_sel,
   output logic [NUM_SCR-1:0]         scr_sel
);

   logic aligned;
   logic fixed_hit;

   assign aligned = (addr[1:0] == 2'b00);

   for (genvar gi = 0; gi < NUM_OSC; gi++) begin : g_osc_dec
      assign osc_sel[gi] = aligned && (addr == ADDR_W'(OFF_OSC0 + 4 * gi));
   end

   for (genvar gs = 0; gs < NUM_SCR; gs++) begin : g_scr_dec
      assign scr_sel[gs] = aligned && (addr == ADDR_W'(scr_offset(gs)));
   end

   always_comb begin
      sel         = '0;
      sel.sys_id  = aligned && (addr == ADDR_W'(OFF_SYS_ID));
      sel.proc_id = aligned && (addr == ADDR_W'(OFF_PROC_ID));
      sel.lock    = aligned && (addr == ADDR_W'(OFF_LOCK));
      sel.fl_set  = aligned && (addr == ADDR_W'(OFF_FL_SET));
      sel.fl_clr  = aligned && (addr == ADDR_W'(OFF_FL_CLR));
      sel.nv_set  = aligned && (addr == ADDR_W'(OFF_NV_SET));
      sel.nv_clr  = aligned && (addr == ADDR_W'(OFF_NV_CLR));
      sel.rst_ctl = aligned && (addr == ADDR_W'(OFF_RST_CTL));
      sel.tick    = aligned && (addr == ADDR_W'(OFF_TICK));
      fixed_hit   = sel.sys_id | sel.proc_id | sel.lock | sel.fl_set | sel.fl_clr
                  | sel.nv_set | sel.nv_clr | sel.rst_ctl | sel.tick;
      sel.valid   = fixed_hit | (|osc_sel) | (|scr_sel);
   end

endmodule

// File: rtl/sysctl_lock.sv
module sysctl_lock
   import sysctl_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wdata,
   output logic        unlocked,
   output logic [31:0] rd_val
);

   logic [15:0] key_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= '0;
      end else if (wr_en) begin
         if (wdata == {16'h0000, UNLOCK_KEY}) key_q <= UNLOCK_KEY;
         else                                 key_q <= {1'b0, wdata[14:0]};
      end
   end

   assign unlocked = (key_q == UNLOCK_KEY);
   assign rd_val   = {15'b0, ~unlocked, key_q};

endmodule

// File: rtl/sysctl_setclr.sv
module sysctl_setclr #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_en,
   input  logic         clr_en,
   input  logic [W-1:0] mask,
   output logic [W-1:0] q
);

   logic [W-1:0] set_m;
   logic [W-1:0] clr_m;

   assign set_m = set_en ? mask : '0;
   assign clr_m = clr_en ? mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q <= '0;
      else if (set_en || clr_en) q <= (q | set_m) & ~clr_m;
   end

endmodule

// File: rtl/sysctl_tick.sv
module sysctl_tick #(
   parameter int unsigned CLK_HZ  = 48_000_000,
   parameter int unsigned TICK_HZ = 24_000_000,
   parameter int unsigned CNT_W   = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] count
);

   localparam int unsigned ACC_W = $clog2(CLK_HZ) + 1;

   if (TICK_HZ == CLK_HZ) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) count <= '0;
         else        count <= count + 1'b1;
      end
   end else begin : g_phase
      logic [ACC_W-1:0] acc_q;
      logic [ACC_W-1:0] acc_sum;
      logic             wrap;

      assign acc_sum = acc_q + ACC_W'(TICK_HZ);
      assign wrap    = (acc_sum >= ACC_W'(CLK_HZ));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_q <= '0;
            count <= '0;
         end else if (wrap) begin
            acc_q <= acc_sum - ACC_W'(CLK_HZ);
            count <= count + 1'b1;
         end else begin
            acc_q <= acc_sum;
         end
      end
   end

endmodule

// File: rtl/sys_ctrl_bank.sv
module sys_ctrl_bank
   import sysctl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter logic [31:0] SYS_ID   = 32'h1780_0500,
   parameter logic [31:0] PROC_ID  = 32'h0C00_0000,
   parameter int unsigned NUM_OSC  = 5,
   parameter logic [31:0] OSC_RST  = 32'h0,
   parameter int unsigned FLAG_W   = 32,
   parameter int unsigned RSTCTL_W = 8,
   parameter int unsigned CLK_HZ   = 48_000_000,
   parameter int unsigned TICK_HZ  = 24_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_err,
   output logic              rst_req
);

   localparam int unsigned CNT_W = 32;

   if (ADDR_W < 8 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must lie in 8..16");
   end
   if (NUM_OSC < 1 || NUM_OSC > MAX_OSC) begin : g_bad_osc
      $error("NUM_OSC must lie in 1..5");
   end
   if (FLAG_W < 1 || FLAG_W > 32) begin : g_bad_flag
      $error("FLAG_W must lie in 1..32");
   end
   if (RSTCTL_W < 1 || RSTCTL_W > 32) begin : g_bad_rc
      $error("RSTCTL_W must lie in 1..32");
   end
   if (TICK_HZ < 1 || TICK_HZ > CLK_HZ) begin : g_bad_tick
      $error("TICK_HZ must lie in 1..CLK_HZ");
   end

   sel_t                 sel;
   logic [NUM_OSC-1:0]   osc_sel;
   logic [NUM_SCR-1:0]   scr_sel;
   logic                 unlocked;
   logic [31:0]          lock_rd;
   logic [FLAG_W-1:0]    vflag_q;
   logic [FLAG_W-1:0]    nvflag_q;
   logic [CNT_W-1:0]     tick_cnt;
   logic [RSTCTL_W-1:0]  rstc_q;
   logic [31:0]          osc_q [NUM_OSC];
   logic [31:0]          scr_q [NUM_SCR];
   logic [31:0]          rmux;
   logic                 rstc_take;

   sysctl_decode #(.ADDR_W(ADDR_W), .NUM_OSC(NUM_OSC)) u_dec (
      .addr    (bus_addr),
      .sel     (sel),
      .osc_sel (osc_sel),
      .scr_sel (scr_sel)
   );

   sysctl_lock u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr & sel.lock),
      .wdata    (bus_wdata),
      .unlocked (unlocked),
      .rd_val   (lock_rd)
   );

   sysctl_setclr #(.W(FLAG_W)) u_vflags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (bus_wr & sel.fl_set),
      .clr_en (bus_wr & sel.fl_clr),
      .mask   (bus_wdata[FLAG_W-1:0]),
      .q      (vflag_q)
   );

   sysctl_setclr #(.W(FLAG_W)) u_nvflags (
      .clk    (clk),
      .rst_n  (por_n),
      .set_en (bus_wr & sel.nv_set),
      .clr_en (bus_wr & sel.nv_clr),
      .mask   (bus_wdata[FLAG_W-1:0]),
      .q      (nvflag_q)
   );

   sysctl_tick #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .CNT_W(CNT_W)) u_tick (
      .clk   (clk),
      .rst_n (por_n),
      .count (tick_cnt)
   );

   for (genvar gi = 0; gi < NUM_OSC; gi++) begin : g_osc
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      osc_q[gi] <= OSC_RST;
         else if (bus_wr && osc_sel[gi])  osc_q[gi] <= bus_wdata;
      end
   end

   for (genvar gs = 0; gs < NUM_SCR; gs++) begin : g_scr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      scr_q[gs] <= '0;
         else if (bus_wr && scr_sel[gs])  scr_q[gs] <= bus_wdata;
      end
   end

   assign rstc_take = bus_wr & sel.rst_ctl & unlocked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rstc_q  <= '0;
         rst_req <= 1'b0;
         bus_err <= 1'b0;
      end else begin
         if (rstc_take) rstc_q <= bus_wdata[RSTCTL_W-1:0];
         rst_req <= rstc_take;
         bus_err <= (bus_wr | bus_rd) & ~sel.valid;
      end
   end

   always_comb begin
      rmux = '0;
      if (sel.sys_id)  rmux = SYS_ID;
      if (sel.proc_id) rmux = PROC_ID;
      if (sel.lock)    rmux = lock_rd;
      if (sel.fl_set)  rmux = 32'(vflag_q);
      if (sel.nv_set)  rmux = 32'(nvflag_q);
      if (sel.rst_ctl) rmux = 32'(rstc_q);
      if (sel.tick)    rmux = 32'(tick_cnt);
      for (int i = 0; i < NUM_OSC; i++) begin
         if (osc_sel[i]) rmux = osc_q[i];
      end
      for (int j = 0; j < NUM_SCR; j++) begin
         if (scr_sel[j]) rmux = scr_q[j];
      end
   end

   assign bus_rdata = bus_rd ? rmux : 32'h0;

endmodule

// File: rtl/sysctl_chk.sv
module sysctl_chk
   import sysctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned FLAG_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              bus_err,
   input logic              rst_req,
   input logic              unlocked,
   input logic [FLAG_W-1:0] vflags
);

   logic lock_wr;
   logic rstc_wr;
   assign lock_wr = bus_wr && (bus_addr == ADDR_W'(OFF_LOCK));
   assign rstc_wr = bus_wr && (bus_addr == ADDR_W'(OFF_RST_CTL));

   // R3
   key_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_wr && bus_wdata == 32'h0000_A05F) |=> unlocked);

   // R4
   bad_key_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_wr && bus_wdata != 32'h0000_A05F) |=> !unlocked);

   // R5
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFF_FL_SET))
      |=> ((vflags & $past(bus_wdata[FLAG_W-1:0])) == $past(bus_wdata[FLAG_W-1:0])));

   // R7
   req_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(rstc_wr && unlocked));

   // R7
   locked_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rstc_wr && !unlocked) |=> !rst_req);

   // R9
   unaligned_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_wr || bus_rd) && bus_addr[1:0] != 2'b00) |=> bus_err);

   // R12
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == 32'h0));

endmodule

bind sys_ctrl_bank sysctl_chk #(.ADDR_W(ADDR_W), .FLAG_W(FLAG_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .bus_err   (bus_err),
   .rst_req   (rst_req),
   .unlocked  (unlocked),
   .vflags    (vflag_q)
);

// File: tb/test_sys_ctrl_bank.sv
module test_sys_ctrl_bank;

   localparam int PERIOD = 10;
   localparam logic [31:0] SYS_ID  = 32'h1780_0500;
   localparam logic [31:0] PROC_ID = 32'h0C00_0000;
   localparam longint CLK_HZ  = 48_000_000;
   localparam longint TICK_HZ = 24_000_000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        por_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_err;
   logic        rst_req;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   string cur_req = "R10";

   sys_ctrl_bank #(.SYS_ID(SYS_ID), .PROC_ID(PROC_ID)) i_sys_ctrl_bank (
      .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_err(bus_err), .rst_req(rst_req)
   );

   always #(PERIOD/2) clk = ~clk;

   // behavioural reference model
   logic [31:0] m_osc [5];
   logic [31:0] m_scr [int];
   logic [15:0] m_lock;
   logic [31:0] m_fl, m_nv, m_cnt;
   logic [7:0]  m_rc;
   longint      m_acc;
   bit          m_err, m_req;

   function automatic bit is_scr(input logic [11:0] a);
      return a == 12'h028 || a == 12'h02C || a == 12'h044 ||
             a == 12'h04C || a == 12'h050 || a == 12'h054;
   endfunction

   function automatic bit is_def(input logic [11:0] a);
      if (a[1:0] != 2'b00) return 0;
      if (a >= 12'h00C && a <= 12'h01C) return 1;
      if (is_scr(a)) return 1;
      case (a)
         12'h000, 12'h084, 12'h020, 12'h030, 12'h034, 12'h038,
         12'h03C, 12'h040, 12'h05C: return 1;
         default: return 0;
      endcase
   endfunction

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      if (!is_def(a)) return 32'h0;
      if (a >= 12'h00C && a <= 12'h01C) return m_osc[(a - 12'h00C) / 4];
      if (is_scr(a)) return m_scr.exists(int'(a)) ? m_scr[int'(a)] : 32'h0;
      case (a)
         12'h000: return SYS_ID;
         12'h084: return PROC_ID;
         12'h020: return {15'b0, (m_lock != 16'hA05F), m_lock};
         12'h030: return m_fl;
         12'h038: return m_nv;
         12'h040: return {24'b0, m_rc};
         12'h05C: return m_cnt;
         default: return 32'h0;
      endcase
   endfunction

   task automatic clear_volatile();
      for (int i = 0; i < 5; i++) m_osc[i] = '0;
      m_scr.delete();
      m_lock = '0; m_fl = '0; m_rc = '0; m_err = 0; m_req = 0;
   endtask

   task automatic clear_por();
      m_nv = '0; m_cnt = '0; m_acc = 0;
   endtask

   always @(posedge clk) begin
      if (!por_n) clear_por();
      else begin
         m_acc += TICK_HZ;
         if (m_acc >= CLK_HZ) begin m_acc -= CLK_HZ; m_cnt++; end
      end
      if (!rst_n) clear_volatile();
      else begin
         m_err = (bus_rd || bus_wr) && !is_def(bus_addr);
         m_req = bus_wr && bus_addr == 12'h040 && m_lock == 16'hA05F;
         if (bus_wr && is_def(bus_addr)) begin
            if (bus_addr >= 12'h00C && bus_addr <= 12'h01C)
               m_osc[(bus_addr - 12'h00C) / 4] = bus_wdata;
            else if (is_scr(bus_addr)) m_scr[int'(bus_addr)] = bus_wdata;
            else case (bus_addr)
               12'h020: m_lock = (bus_wdata == 32'h0000_A05F) ? 16'hA05F : {1'b0, bus_wdata[14:0]};
               12'h030: m_fl = m_fl | bus_wdata;
               12'h034: m_fl = m_fl & ~bus_wdata;
               12'h038: m_nv = m_nv | bus_wdata;
               12'h03C: m_nv = m_nv & ~bus_wdata;
               12'h040: if (m_lock == 16'hA05F) m_rc = bus_wdata[7:0];
               default: ;
            endcase
         end
      end
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (!por_n) clear_por();
      if (!rst_n) clear_volatile();
      if (!done) begin
         check(bus_rd ? cur_req : "R12", "rdata", bus_rdata,
               bus_rd ? exp_read(bus_addr) : 32'h0);
         check("R9", "bus_err", 32'(bus_err), 32'(m_err));
         check("R7", "rst_req", 32'(rst_req), 32'(m_req));
      end
   end

   task automatic drive(input string req, input bit w, input bit r,
                        input logic [11:0] a, input logic [31:0] d);
      @(posedge clk);
      #1;
      cur_req = req; bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
   endtask

   task automatic wr(input string req, input logic [11:0] a, input logic [31:0] d);
      drive(req, 1, 0, a, d);
   endtask

   task automatic rd(input string req, input logic [11:0] a);
      drive(req, 0, 1, a, 32'h0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive("R12", 0, 0, 12'h020, 32'h0);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired at %0t", $time);
         done = 1;
         summary();
         $finish;
      end
   end

   initial begin
      clear_volatile();
      clear_por();
      repeat (3) @(posedge clk);
      #1; por_n = 1'b1; rst_n = 1'b1;
      // R10 reset state
      rd("R10", 12'h020); rd("R10", 12'h030); rd("R10", 12'h00C); rd("R10", 12'h040);
      // R1 identity words, writes ignored
      rd("R1", 12'h000); rd("R1", 12'h084);
      wr("R1", 12'h000, 32'hDEAD_BEEF); wr("R1", 12'h084, 32'h1234_5678);
      rd("R1", 12'h000); rd("R1", 12'h084);
      // R2 oscillator words
      for (int i = 0; i < 5; i++) wr("R2", 12'(12'h00C + 4 * i), 32'hA5A5_0000 + i);
      for (int i = 0; i < 5; i++) rd("R2", 12'(12'h00C + 4 * i));
      // R11 storage words
      wr("R11", 12'h028, 32'h1111_2222); wr("R11", 12'h054, 32'hFFFF_0001);
      wr("R11", 12'h044, 32'h0BAD_F00D);
      rd("R11", 12'h028); rd("R11", 12'h054); rd("R11", 12'h044); rd("R11", 12'h050);
      // R4 wrong key while locked, then reset control must be ignored (R7)
      wr("R4", 12'h020, 32'h1234_FFFF); rd("R4", 12'h020);
      wr("R7", 12'h040, 32'h0000_00C3); idle(1); rd("R7", 12'h040);
      // R3 exact key unlocks
      wr("R3", 12'h020, 32'h0000_A05F); rd("R3", 12'h020);
      // R7 accepted write and back-to-back pulses
      wr("R7", 12'h040, 32'h0000_015A); idle(2); rd("R7", 12'h040);
      wr("R7", 12'h040, 32'h0000_0001); wr("R7", 12'h040, 32'h0000_0002); idle(2);
      // R4 key match only in the low half relocks
      wr("R4", 12'h020, 32'h0001_A05F); rd("R4", 12'h020);
      wr("R7", 12'h040, 32'h0000_00FF); idle(1); rd("R7", 12'h040);
      // R5 volatile flags
      wr("R5", 12'h030, 32'hF0F0_00FF); rd("R5", 12'h030);
      wr("R5", 12'h030, 32'h0000_FF00); rd("R5", 12'h030);
      wr("R5", 12'h034, 32'h00F0_0F0F); rd("R5", 12'h030); rd("R5", 12'h034);
      // R6 non-volatile flags
      wr("R6", 12'h038, 32'h8000_0003); wr("R6", 12'h03C, 32'h0000_0001);
      rd("R6", 12'h038); rd("R6", 12'h03C);
      // R9 undefined and unaligned offsets
      wr("R9", 12'h008, 32'hFFFF_FFFF); rd("R9", 12'h008);
      wr("R9", 12'h00D, 32'h0000_0077); rd("R9", 12'h00C); rd("R9", 12'h00D);
      rd("R9", 12'h024); wr("R9", 12'hFFC, 32'h1); rd("R9", 12'hFFC);
      rd("R9", 12'h058); idle(1);
      // R8 tick counter, write ignored
      rd("R8", 12'h05C); wr("R8", 12'h05C, 32'h0);
      for (int i = 0; i < 7; i++) rd("R8", 12'h05C);
      // R12 read strobe low on a live address
      drive("R12", 0, 0, 12'h030, 32'h0); drive("R12", 0, 0, 12'h05C, 32'h0);
      // R10 bus reset keeps non-volatile flags and counter (R6, R8)
      wr("R3", 12'h020, 32'h0000_A05F);
      @(posedge clk); #1; bus_wr = 0; bus_rd = 0; rst_n = 1'b0;
      @(posedge clk); #1; rst_n = 1'b1;
      rd("R10", 12'h020); rd("R10", 12'h030); rd("R10", 12'h010);
      rd("R10", 12'h028); rd("R10", 12'h040);
      rd("R6", 12'h038); rd("R8", 12'h05C);
      for (int i = 0; i < 200; i++) rd("R8", 12'h05C);
      // R6 power-on reset clears non-volatile flags
      @(posedge clk); #1; bus_rd = 0; rst_n = 1'b0; por_n = 1'b0;
      @(posedge clk); #1; rst_n = 1'b1; por_n = 1'b1;
      rd("R6", 12'h038); rd("R8", 12'h05C); idle(2);
      done = 1;
      summary();
      $finish;
   end

endmodule